// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block turns the system clock into the serial clock of an SPI controller. The system clock is first slowed by a power-of-two prescaler whose exponent comes from a scale input. Two separate step counts then shape the serial clock. One count sets how many prescaled steps the clock rests in its idle-level phase. The other sets how many steps it spends in the opposite phase. This gives control over both frequency and duty cycle.

A transaction sequencer raises `enable` for as long as it needs serial clock edges. It takes the one-cycle `sample_stb` and `shift_stb` pulses to drive its shift register. Polarity and phase inputs choose among the four SPI modes. Polarity sets the level the clock rests at. Phase decides whether the first or the second edge of each bit carries the sample. Lowering `enable`, or programming either step count to zero, stops the clock at its idle level and clears all internal counting. The next start is then timed from scratch.

Top module: `spiclk_gen`

## Requirements
- R1: While running, one prescaled step lasts exactly 2^scale system clock cycles, with scale taken as an unsigned 4-bit value (0 to 15).
- R2: After the clock starts, the first phase lasts lo_count steps and every later phase at the idle level also lasts lo_count steps. The first edge therefore comes lo_count x 2^scale cycles after the first running cycle.
- R3: Each phase at the non-idle level lasts hi_count steps, i.e. hi_count x 2^scale system cycles.
- R4: If lo_count or hi_count is zero, no clock is generated. sclk stays at the idle level and neither strobe pulses, even with enable high.
- R5: The idle level of sclk equals cpol. The whole waveform is inverted when cpol is 1.
- R6: With cpha = 0, sample_stb pulses on every leading edge (idle level to active level) and shift_stb pulses on every trailing edge.
- R7: With cpha = 1, sample_stb pulses on every trailing edge and shift_stb pulses on every leading edge.
- R8: Each strobe is high for exactly the one system cycle in which sclk takes its new level. The two strobes are never high together.
- R9: When enable falls, sclk is at the idle level in the next cycle and the prescaler and phase counters are cleared. After a new rise of enable, the first edge again follows the timing of R2.
- R10: During and right after reset, sclk equals cpol and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request from the transaction sequencer |
| scale | input | 4 | Prescaler exponent; one step is 2^scale cycles |
| lo_count | input | 8 | Steps spent at the idle level; 0 stops generation |
| hi_count | input | 8 | Steps spent at the active level; 0 stops generation |
| cpol | input | 1 | Clock polarity: idle level of sclk |
| cpha | input | 1 | Clock phase: 0 samples on the leading edge, 1 on the trailing edge |
| sclk | output | 1 | Serial clock |
| sample_stb | output | 1 | One-cycle pulse where the receive bit is to be sampled |
| shift_stb | output | 1 | One-cycle pulse where the next transmit bit is to be shifted out |

## Verification
The range assertions on the prescaler and phase counters assume that scale, lo_count and hi_count do not change while the clock is running. A mid-run change could leave a counter above a newly lowered limit for one step. The stimulus respects this: it changes the configuration only while enable is low, and cpol and cpha only while the generator is idle. The bench covers all four modes, the extreme scales 0 and 15, unequal duty counts, zero counts, and disabling in the middle of a phase.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE  = 2'd0,
    EDGE_LEAD  = 2'd1,
    EDGE_TRAIL = 2'd2
  } sclk_edge_e;

  typedef struct packed {
    logic cpol;
    logic cpha;
  } spi_mode_t;

  // sampling edge: leading edge for phase 0, trailing edge for phase 1
  function automatic logic samples_on(input spi_mode_t m, input sclk_edge_e e);
    return (e == EDGE_LEAD && !m.cpha) || (e == EDGE_TRAIL && m.cpha);
  endfunction

  // shifting uses the edge opposite to the sampling edge
  function automatic logic shifts_on(input spi_mode_t m, input sclk_edge_e e);
    return (e == EDGE_TRAIL && !m.cpha) || (e == EDGE_LEAD && m.cpha);
  endfunction

endpackage

// File: rtl/spiclk_prescaler.sv
module spiclk_prescaler #(
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);
  localparam int PRE_W = (1 << SCALE_W) - 1;

  logic [PRE_W-1:0] pre_q;

  // last count value of a step: 2^s - 1, built as a thermometer mask
  function automatic logic [PRE_W-1:0] wrap_value(input logic [SCALE_W-1:0] s);
    logic [PRE_W-1:0] m;
    for (int i = 0; i < PRE_W; i++) m[i] = (i < int'(s));
    return m;
  endfunction

  assign tick = run && (pre_q >= wrap_value(scale));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pre_q <= '0;
    else if (!run||tick) pre_q <= '0;
    else                 pre_q <= pre_q + PRE_W'(1);
  end

  AST_PRE_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0)); // R9

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && $stable(scale) |-> (pre_q <= wrap_value(scale))); // R1

endmodule

// File: rtl/spiclk_phase.sv
module spiclk_phase
  import spiclk_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic [COUNT_W-1:0] lo_count,
  input  logic [COUNT_W-1:0] hi_count,
  output logic               level,
  output sclk_edge_e         edge_kind
);
  logic [COUNT_W-1:0] cnt_q;
  logic               lvl_q;
  logic               expire;

  function automatic logic [COUNT_W-1:0] phase_limit(input logic l,
      input logic [COUNT_W-1:0] lo, input logic [COUNT_W-1:0] hi);
    return l ? hi : lo;
  endfunction

  function automatic logic phase_expires(input logic [COUNT_W-1:0] c,
                                         input logic [COUNT_W-1:0] lim);
    return ({1'b0, c} + {{COUNT_W{1'b0}}, 1'b1}) >= {1'b0, lim};
  endfunction

  assign expire = tick && phase_expires(cnt_q, phase_limit(lvl_q, lo_count, hi_count));

  always_comb begin
    if (!expire)    edge_kind = EDGE_NONE;
    else if (lvl_q) edge_kind = EDGE_TRAIL;
    else            edge_kind = EDGE_LEAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (tick) begin
      if (expire) begin
        cnt_q <= '0;
        lvl_q <= ~lvl_q;
      end else begin
        cnt_q <= cnt_q + COUNT_W'(1);
      end
    end
  end

  assign level = lvl_q;

  AST_IDLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!lvl_q && cnt_q == '0)); // R4

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && $stable(lo_count) && $stable(hi_count)
      |-> (cnt_q < phase_limit(lvl_q, lo_count, hi_count))); // R2

  AST_LVL_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && (lvl_q != $past(lvl_q)) |-> ($past(edge_kind) != EDGE_NONE)); // R3

endmodule

// File: rtl/spiclk_strobe.sv
module spiclk_strobe
  import spiclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  sclk_edge_e edge_kind,
  input  spi_mode_t  mode,
  output logic       sample_stb,
  output logic       shift_stb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_stb <= 1'b0;
      shift_stb  <= 1'b0;
    end else if (!run) begin
      sample_stb <= 1'b0;
      shift_stb  <= 1'b0;
    end else begin
      sample_stb <= samples_on(mode, edge_kind);
      shift_stb  <= shifts_on(mode, edge_kind);
    end
  end

  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && shift_stb)); // R8

  AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb); // R8

  AST_STB_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || shift_stb) |-> ($past(edge_kind) != EDGE_NONE)); // R6

endmodule

// File: rtl/spiclk_gen.sv
module spiclk_gen
  import spiclk_pkg::*;
#(
  parameter int SCALE_W = 4,
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [SCALE_W-1:0] scale,
  input  logic [COUNT_W-1:0] lo_count,
  input  logic [COUNT_W-1:0] hi_count,
  input  logic               cpol,
  input  logic               cpha,
  output logic               sclk,
  output logic               sample_stb,
  output logic               shift_stb
);
  logic       run;
  logic       tick;
  logic       raw_level;
  sclk_edge_e edge_kind;
  spi_mode_t  mode;

  assign run  = enable && (lo_count != '0) && (hi_count != '0);
  assign mode = '{cpol: cpol, cpha: cpha};

  spiclk_prescaler #(.SCALE_W(SCALE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .scale (scale),
    .tick  (tick)
  );

  spiclk_phase #(.COUNT_W(COUNT_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .lo_count  (lo_count),
    .hi_count  (hi_count),
    .level     (raw_level),
    .edge_kind (edge_kind)
  );

  spiclk_strobe u_stb (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .edge_kind  (edge_kind),
    .mode       (mode),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb)
  );

  // polarity applied last so both levels share one counting path
  assign sclk = raw_level ^ cpol;

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sclk == cpol)); // R5

  AST_STB_ON_SCLK_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cpol) && (sample_stb || shift_stb) |-> (sclk != $past(sclk))); // R8

endmodule

// File: tb/test_spiclk_gen.sv
module test_spiclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] scale = '0;
  logic [7:0] lo_count = 8'd1;
  logic [7:0] hi_count = 8'd1;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       sclk, sample_stb, shift_stb;

  always #2 clk = ~clk; // 250 MHz

  spiclk_gen i_spiclk_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scale(scale),
    .lo_count(lo_count), .hi_count(hi_count), .cpol(cpol), .cpha(cpha),
    .sclk(sclk), .sample_stb(sample_stb), .shift_stb(shift_stb)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  string tag    = "R10";

  // behavioural reference: system cycles elapsed in the current phase
  int m_lvl = 0;
  int m_cyc = 0;
  bit m_samp = 0;
  bit m_shift = 0;

  always @(posedge clk) begin
    cycles++;
    m_samp  = 0;
    m_shift = 0;
    if (!rst_n || !enable || lo_count == 0 || hi_count == 0) begin
      m_lvl = 0;
      m_cyc = 0;
    end else begin
      int len;
      bit leading;
      m_cyc++;
      len = (m_lvl == 1 ? int'(hi_count) : int'(lo_count)) * (1 << scale);
      if (m_cyc == len) begin
        leading = (m_lvl == 0);
        m_lvl   = 1 - m_lvl;
        m_cyc   = 0;
        if (leading != cpha) m_samp = 1;
        else                 m_shift = 1;
      end
    end
  end

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("sclk", sclk, logic'(m_lvl[0]) ^ cpol);
    chk("sample_stb", sample_stb, m_samp);
    chk("shift_stb", shift_stb, m_shift);
    checks++;
    if (sample_stb && shift_stb) begin // R8 exclusivity
      fails++;
      $display("FAIL R8 both strobes: actual 11 expected not both at %0t", $time);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic run_cfg(input string t, input int s, input int lo, input int hi,
                         input bit pol, input bit pha, input int n);
    step(1);
    enable = 1'b0;
    step(2);
    tag = t;
    scale = 4'(s); lo_count = 8'(lo); hi_count = 8'(hi);
    cpol = pol; cpha = pha;
    step(2);
    enable = 1'b1;
    step(n);
    enable = 1'b0;
    step(3);
  endtask

  initial begin
    int limit_cycles = 190000;
    wait (cycles >= limit_cycles);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tag = "R10";
    cpol = 1'b1;
    step(3);
    cpol = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(3);
    run_cfg("R1", 0, 1, 1, 0, 0, 40);
    run_cfg("R1", 3, 1, 1, 0, 0, 100);
    run_cfg("R1", 15, 1, 1, 0, 0, 70000);
    run_cfg("R2", 1, 5, 2, 0, 0, 200);
    run_cfg("R3", 2, 1, 6, 0, 1, 300);
    run_cfg("R3", 0, 255, 255, 0, 0, 1100);
    for (int m = 0; m < 4; m++) begin
      run_cfg((m % 2 == 0) ? "R6" : "R7", m, 2, 3, m[1], m[0], 400);
    end
    run_cfg("R5", 1, 3, 1, 1, 0, 120);
    run_cfg("R4", 0, 0, 4, 0, 0, 40);
    run_cfg("R4", 2, 3, 0, 1, 1, 40);
    run_cfg("R9", 1, 4, 2, 0, 1, 13);
    tag = "R9";
    enable = 1'b1;
    step(9);
    enable = 1'b0;
    step(1);
    enable = 1'b1;
    step(60);
    enable = 1'b0;
    step(4);
    tag = "R10";
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule